// File: doc/BRIEF.md
# Phased Instruction-Cycle Processor Core

This block is a small 16-bit stored-program core in which every instruction passes through an explicit sequence of phases. The phases are fetch, decode, evaluate address, fetch operands, execute and store result. Fetch is broken into micro-steps. The memory address register is loaded from the program counter, a wait clock covers the memory latency, the data register captures the read word, the instruction register copies the data register, and finally the program counter is incremented. After decode, each opcode takes only the phases it needs and then returns to fetch.

The core drives a single-port synchronous word memory with one clock of read latency. A run latch gates every state change. Reset sets the latch, and a halt instruction clears it. The current phase, program counter and instruction register are brought out so that a surrounding system can follow the cycle. Apart from the opcodes listed below, all other opcodes pass through decode and do nothing else.

Top module: `phased_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all eight general registers, sets the run latch (`running`=1) and starts the fetch phase.
- R2: The `phase` output is encoded as 0 fetch, 1 decode, 2 evaluate address, 3 fetch operands, 4 execute, 5 store result. Fetch lasts five clocks. The instruction register holds the word at the old PC four clocks after fetch starts, and the PC reads old PC+1 one clock later, when decode begins.
- R3: Opcode 4'b0001 (add) has destination [11:9], first source [8:6] and second source [2:0]. It writes the 16-bit wrapped sum of the two sources to the destination. It follows phases 0,1,3,4,5 and takes 9 clocks.
- R4: Opcode 4'b0110 (load) has destination [11:9], base [8:6] and offset [5:0]. The offset is zero-extended and added to the base to form the address. That address is on `mem_addr` during the fetch-operands phase, and the word read there is written to the destination. It follows phases 0,1,2,3,5 and takes 10 clocks.
- R5: Opcode 4'b0000 (branch) sign-extends bits [8:0] and adds them to the already incremented PC. It follows phases 0,1,4 and takes 7 clocks.
- R6: Opcode 4'b1111 (halt) clears the run latch at the end of decode (phases 0,1, 6 clocks). After that, the PC, phase, instruction register and memory address stay fixed until reset.
- R7: Any other opcode follows phases 0,1, takes 6 clocks, changes no general register and leaves the run latch set.
- R8: The core never writes memory: `mem_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address (memory address register) |
| mem_wdata | output | 16 | Memory write data (always zero) |
| mem_we | output | 1 | Memory write enable (always low) |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| running | output | 1 | Run latch state |
| phase | output | 3 | Current instruction-cycle phase code |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |

## Verification
Each opcode is run while the bench traces the sequence of phase codes and counts clocks. This separates a skipped phase from an extra one or a missing wait state. Register contents are read back through the load address: a probe load with offset 0 puts the base register on `mem_addr`. The add operands are chosen so that one sum wraps past 16 bits and one source is added to itself. The load offset 63 separates zero extension from sign extension. The branch is exercised forwards and backwards, so a sign or base-PC error shows up in the target. A halt followed by idle clocks, and an unassigned opcode whose operand fields are nonzero, check that nothing moves.

// File: rtl/phased_core.sv
module phased_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata,
  output logic         running,
  output logic [2:0]   phase,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] ir_o
);
  localparam int NREG = 8;
  localparam logic [3:0] OP_BR = 4'b0000, OP_ADD = 4'b0001, OP_LD = 4'b0110, OP_HLT = 4'b1111;

  typedef enum logic [3:0] {
    S_FMAR, S_FWAIT, S_FMDR, S_FIR, S_FPC, S_DEC,
    S_EVAL, S_LWAIT, S_LMDR, S_OPER, S_EXEC, S_STORE
  } st_t;

  st_t          st;
  logic [W-1:0] pc, mar, mdr, ir, a, b, res;
  logic [W-1:0] rf [NREG];
  logic         run;

  wire [3:0] op   = ir[15:12];
  wire [2:0] dr   = ir[11:9];
  wire [2:0] sr1  = ir[8:6];
  wire [2:0] sr2  = ir[2:0];
  wire [W-1:0] off6 = {{(W-6){1'b0}}, ir[5:0]};
  wire [W-1:0] off9 = {{(W-9){ir[8]}}, ir[8:0]};

  assign mem_addr  = mar;
  assign mem_wdata = '0;
  assign mem_we    = 1'b0;
  assign running   = run;
  assign pc_o      = pc;
  assign ir_o      = ir;

  always_comb begin
    case (st)
      S_DEC:                   phase = 3'd1;
      S_EVAL:                  phase = 3'd2;
      S_LWAIT, S_LMDR, S_OPER: phase = 3'd3;
      S_EXEC:                  phase = 3'd4;
      S_STORE:                 phase = 3'd5;
      default:                 phase = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_FMAR;
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      a   <= '0;
      b   <= '0;
      res <= '0;
      run <= 1'b1;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (run) begin
      case (st)
        S_FMAR:  begin mar <= pc; st <= S_FWAIT; end
        S_FWAIT: st <= S_FMDR;
        S_FMDR:  begin mdr <= mem_rdata; st <= S_FIR; end
        S_FIR:   begin ir <= mdr; st <= S_FPC; end
        S_FPC:   begin pc <= pc + 1'b1; st <= S_DEC; end
        S_DEC: begin
          case (op)
            OP_ADD:  st <= S_OPER;
            OP_LD:   st <= S_EVAL;
            OP_BR:   st <= S_EXEC;
            OP_HLT:  begin run <= 1'b0; st <= S_FMAR; end
            default: st <= S_FMAR;
          endcase
        end
        S_EVAL:  begin mar <= rf[sr1] + off6; st <= S_LWAIT; end
        S_LWAIT: st <= S_LMDR;
        S_LMDR:  begin mdr <= mem_rdata; st <= S_STORE; end
        S_OPER:  begin a <= rf[sr1]; b <= rf[sr2]; st <= S_EXEC; end
        S_EXEC: begin
          if (op == OP_BR) begin
            pc <= pc + off9;
            st <= S_FMAR;
          end else begin
            res <= a + b;
            st  <= S_STORE;
          end
        end
        S_STORE: begin
          rf[dr] <= (op == OP_LD) ? mdr : res;
          st     <= S_FMAR;
        end
        default: st <= S_FMAR;
      endcase
    end
  end

  p_decode_follows_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC) |-> ($past(st) == S_FPC));

  p_add_skips_eval_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_OPER) |-> ($past(st) == S_DEC && op == OP_ADD));

  p_load_skips_exec_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_STORE && op == OP_LD) |-> ($past(st) == S_LMDR));

  p_pc_moves_legally_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> ($past(st) == S_FPC || ($past(st) == S_EXEC && $past(op) == OP_BR)));

  p_stop_only_on_halt_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> ($past(st) == S_DEC && $past(op) == OP_HLT));

  p_frozen_when_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(pc) && $stable(st) && $stable(mar) && $stable(ir)));
endmodule

// File: tb/tb_phased_core.sv
module tb_phased_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_o, ir_o;
  logic        mem_we, running;
  logic [2:0]  phase;
  logic [15:0] mem [256];
  int          n_chk = 0, n_fail = 0, cycles = 0;

  phased_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .running(running), .phase(phase), .pc_o(pc_o), .ir_o(ir_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [15:0] e_add(input int d, input int s1, input int s2);
    return {4'b0001, d[2:0], s1[2:0], 3'b000, s2[2:0]};
  endfunction
  function automatic logic [15:0] e_ld(input int d, input int bs, input int off);
    return {4'b0110, d[2:0], bs[2:0], off[5:0]};
  endfunction
  function automatic logic [15:0] e_br(input int off);
    return {4'b0000, 3'b000, off[8:0]};
  endfunction

  localparam logic [23:0] SEQ_ADD = {9'd0, 3'd0, 3'd1, 3'd3, 3'd4, 3'd5};
  localparam logic [23:0] SEQ_LD  = {9'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
  localparam logic [23:0] SEQ_BR  = {15'd0, 3'd0, 3'd1, 3'd4};
  localparam logic [23:0] SEQ_SHORT = {18'd0, 3'd0, 3'd1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic run_instr(output logic [23:0] seq, output int cyc, output logic [15:0] ea);
    logic [2:0] last;
    seq = '0; cyc = 0; last = 3'd7; ea = '0;
    forever begin
      if (phase != last) begin seq = {seq[20:0], phase}; last = phase; end
      if (phase == 3'd3) ea = mem_addr;
      @(posedge clk); #1; cyc++;
      if ((phase == 3'd0 && last != 3'd0) || cyc > 60) break;
    end
  endtask

  task automatic t_reset_fetch();
    logic [23:0] s; int c; logic [15:0] ea;
    mem[0] = 16'h5000;
    mem[1] = e_ld(5, 6, 0);
    mem[2] = 16'hF000;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 pc after reset", pc_o, 16'h0000);
    chk("R1 phase after reset", phase, 3'd0);
    chk("R1 running after reset", running, 1'b1);
    chk("R8 write enable low", mem_we, 1'b0);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R2 ir after four clocks", ir_o, 16'h5000);
    chk("R2 pc not yet moved", pc_o, 16'h0000);
    @(posedge clk); #1;
    chk("R2 pc incremented at decode", pc_o, 16'h0001);
    chk("R2 decode phase", phase, 3'd1);
    @(posedge clk); #1;
    chk("R7 back to fetch after decode", phase, 3'd0);
    chk("R7 still running", running, 1'b1);
    run_instr(s, c, ea);
    chk("R1 cleared base register seen as address", ea, 16'h0000);
  endtask

  task automatic t_add();
    logic [23:0] s; int c; logic [15:0] ea;
    do_reset();
    mem[40] = 16'h1234; mem[41] = 16'h0F0F; mem[42] = 16'hFFFF; mem[43] = 16'h0002;
    mem[0] = e_ld(1, 0, 40);
    mem[1] = e_ld(2, 0, 41);
    mem[2] = e_add(3, 1, 2);
    mem[3] = e_ld(7, 3, 0);
    mem[4] = e_ld(4, 0, 42);
    mem[5] = e_ld(5, 0, 43);
    mem[6] = e_add(6, 4, 5);
    mem[7] = e_ld(7, 6, 0);
    mem[8] = e_add(6, 1, 1);
    mem[9] = e_ld(7, 6, 0);
    run_instr(s, c, ea);
    chk("R4 load phase path", s, SEQ_LD);
    chk("R4 load clocks", c, 10);
    chk("R4 load address", ea, 16'd40);
    run_instr(s, c, ea);
    run_instr(s, c, ea);
    chk("R3 add phase path", s, SEQ_ADD);
    chk("R3 add clocks", c, 9);
    run_instr(s, c, ea);
    chk("R3 sum 1234+0F0F", ea, 16'h2143);
    repeat (3) run_instr(s, c, ea);
    run_instr(s, c, ea);
    chk("R3 wrapped sum FFFF+0002", ea, 16'h0001);
    run_instr(s, c, ea);
    run_instr(s, c, ea);
    chk("R3 same source twice", ea, 16'h2468);
  endtask

  task automatic t_load_offset();
    logic [23:0] s; int c; logic [15:0] ea;
    do_reset();
    mem[20] = 16'h0040;
    mem[8'h7F] = 16'hBEEF;
    mem[0] = e_ld(1, 0, 20);
    mem[1] = e_ld(2, 1, 63);
    mem[2] = e_ld(3, 2, 0);
    run_instr(s, c, ea);
    run_instr(s, c, ea);
    chk("R4 offset 63 zero-extended", ea, 16'h007F);
    run_instr(s, c, ea);
    chk("R4 loaded word in destination", ea, 16'hBEEF);
  endtask

  task automatic t_branch();
    logic [23:0] s; int c; logic [15:0] ea;
    do_reset();
    mem[0] = e_br(3);
    mem[4] = e_br(-5);
    run_instr(s, c, ea);
    chk("R5 branch phase path", s, SEQ_BR);
    chk("R5 branch clocks", c, 7);
    chk("R5 forward target", pc_o, 16'h0004);
    run_instr(s, c, ea);
    chk("R5 backward target", pc_o, 16'h0000);
  endtask

  task automatic t_halt();
    logic [23:0] s; int c; logic [15:0] ea, pc0, ir0, ad0;
    logic [2:0] ph0;
    do_reset();
    mem[0] = 16'hF000;
    mem[1] = e_ld(1, 0, 5);
    run_instr(s, c, ea);
    chk("R6 halt phase path", s, SEQ_SHORT);
    chk("R6 halt clocks", c, 6);
    chk("R6 run latch cleared", running, 1'b0);
    pc0 = pc_o; ir0 = ir_o; ad0 = mem_addr; ph0 = phase;
    repeat (20) @(posedge clk);
    #1;
    chk("R6 pc held", pc_o, pc0);
    chk("R6 ir held", ir_o, ir0);
    chk("R6 address held", mem_addr, ad0);
    chk("R6 phase held", phase, ph0);
    chk("R8 no write while halted", mem_we, 1'b0);
  endtask

  task automatic t_other_op();
    logic [23:0] s; int c; logic [15:0] ea;
    do_reset();
    mem[30] = 16'h0077;
    mem[0] = e_ld(1, 0, 30);
    mem[1] = 16'h53FF;
    mem[2] = e_ld(7, 1, 0);
    run_instr(s, c, ea);
    run_instr(s, c, ea);
    chk("R7 unassigned opcode path", s, SEQ_SHORT);
    chk("R7 unassigned opcode clocks", c, 6);
    chk("R7 still running", running, 1'b1);
    run_instr(s, c, ea);
    chk("R7 register untouched", ea, 16'h0077);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    t_reset_fetch();
    t_add();
    t_load_offset();
    t_branch();
    t_halt();
    t_other_op();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule